// File: doc/BRIEF.md
# Accelerated-Aging Campaign Scheduler

This block runs an endless wear-out campaign over an array of 49 loop-style delay PUF instances. It alternates between a long stress window and a short measurement window, both counted in ticks of an external scaled time base. During stress it raises the supply and temperature request flags. It drives a 64-bit challenge that is one fixed pattern for the first part of the window and its bitwise complement for the rest. On every stress tick it pulses an activity-enable vector in which PUF groups take part at different fixed rates. This lets one array show several switching-activity levels side by side.

During the measurement window the condition flags drop to nominal, the challenge returns to the first pattern, and a measure-request strobe is issued every few ticks. All window lengths and the request spacing are parameters. A simulation can therefore shrink a campaign from hours to a few dozen ticks. The activity and request strobes are combinational in the tick cycle, so they always line up with the challenge shown in that same cycle.

Top module: `aging_sched`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to tick 0 of a stress window with the 6-bit activation slot counter at 0. With `tick` low after reset, `stress_mode`=1, `measure_mode`=0, `challenge`=64'h00000000FFFFFFFF, `puf_act`=0 and `meas_req`=0.
- R2: A stress window lasts exactly STRESS_LEN ticks and a measurement window exactly MEAS_LEN ticks. The windows alternate without end, and `stress_mode`/`measure_mode` change only in the cycle after the last tick of a window.
- R3: `hi_supply_req` and `hi_temp_req` are 1 exactly when `stress_mode` is 1 (elevated supply and temperature requested), and 0 in measurement (nominal conditions).
- R4: `challenge` is 64'h00000000FFFFFFFF during stress ticks with in-window index below HALF_LEN and during all of the measurement window. It is 64'hFFFFFFFF00000000 during stress ticks with index HALF_LEN or more.
- R5: In every cycle with `tick`=1 during stress, `puf_act` bits 0..7 (PUFs 1 to 8) are all 1.
- R6: `puf_act` bits 8..14 (PUFs 9 to 15) are all 1 on a stress tick whose slot count has its low 3 bits zero, and all 0 on other stress ticks.
- R7: `puf_act` bits 15..30 (PUFs 16 to 31) are all 1 on a stress tick whose slot count is 0 (one stress tick in 64), and all 0 on other stress ticks.
- R8: `puf_act` bits 31..48 (PUFs 32 to 49) are never 1, and `puf_act` is all zero in any cycle that is not a stress tick.
- R9: The slot counter advances by one, modulo 64, on each stress tick only. It keeps its value through measurement windows, so the 1-in-8 and 1-in-64 patterns carry on from one stress window to the next.
- R10: `meas_req` is 1 exactly on measurement ticks whose index within the measurement window is a multiple of MEAS_PERIOD, and never during stress.
- R11: A cycle with `tick`=0 changes no state: mode, challenge and the following slot pattern are unchanged, and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle pulse of the scaled campaign time base |
| stress_mode | output | 1 | 1 during the stress window |
| measure_mode | output | 1 | 1 during the measurement window |
| hi_supply_req | output | 1 | Request for elevated supply voltage |
| hi_temp_req | output | 1 | Request for elevated temperature |
| challenge | output | 64 | Challenge driven to all PUFs |
| puf_act | output | 49 | Per-PUF activation strobe, bit i drives PUF i+1 |
| meas_req | output | 1 | Measurement request strobe |

## Verification
The hardest situation to reach from the ports is the one-in-64 activation of the middle group. Its phase depends on how many stress ticks have gone by across many windows, and measurement windows do not move it. A small configuration (10-tick stress, 6-tick measurement, request every 4 ticks) is driven with an irregular tick pattern for long enough to wrap the slot counter many times, so every slot value meets both challenge halves. A reset in the middle of the campaign then checks that the slot phase and window position restart together.

// File: rtl/aging_pkg.sv
package aging_pkg;

  localparam int N_PUF   = 49;
  localparam int SLOT_W  = 6;
  localparam int CHAL_W  = 64;

  // group boundaries: index of first PUF NOT in the group
  localparam int GRP_FULL_END  = 8;
  localparam int GRP_EIGHT_END = 15;
  localparam int GRP_SIXTY_END = 31;

  localparam logic [CHAL_W-1:0] CHAL_LOW_ONES  = 64'h0000_0000_FFFF_FFFF;
  localparam logic [CHAL_W-1:0] CHAL_HIGH_ONES = ~CHAL_LOW_ONES;

  typedef enum logic {PH_STRESS = 1'b0, PH_MEASURE = 1'b1} phase_e;

  // slot is an eighth-rate slot when its low three bits are zero
  function automatic logic is_eighth_slot(input logic [SLOT_W-1:0] slot);
    return slot[2:0] == 3'd0;
  endfunction

  // slot is a sixty-fourth-rate slot when the whole counter is zero
  function automatic logic is_rare_slot(input logic [SLOT_W-1:0] slot);
    return slot == '0;
  endfunction

  function automatic logic [N_PUF-1:0] activity_mask(input logic [SLOT_W-1:0] slot);
    logic [N_PUF-1:0] m;
    for (int i = 0; i < N_PUF; i++) begin
      if (i < GRP_FULL_END)       m[i] = 1'b1;
      else if (i < GRP_EIGHT_END) m[i] = is_eighth_slot(slot);
      else if (i < GRP_SIXTY_END) m[i] = is_rare_slot(slot);
      else                        m[i] = 1'b0;
    end
    return m;
  endfunction

  function automatic logic [CHAL_W-1:0] challenge_sel(input logic second_half);
    return second_half ? CHAL_HIGH_ONES : CHAL_LOW_ONES;
  endfunction

endpackage

// File: rtl/aging_phase_timer.sv
module aging_phase_timer
  import aging_pkg::*;
#(
  parameter int STRESS_LEN = 1380,
  parameter int HALF_LEN   = 690,
  parameter int MEAS_LEN   = 60
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  output phase_e phase,
  output logic   second_half,
  output logic   phase_last
);

  localparam int MAX_LEN = (STRESS_LEN > MEAS_LEN) ? STRESS_LEN : MEAS_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] STRESS_LAST = CNT_W'(STRESS_LEN - 1);
  localparam logic [CNT_W-1:0] MEAS_LAST   = CNT_W'(MEAS_LEN - 1);
  localparam logic [CNT_W-1:0] HALF_MARK   = CNT_W'(HALF_LEN);

  logic [CNT_W-1:0] idx_q;

  always_comb begin
    if (phase == PH_STRESS) phase_last = (idx_q == STRESS_LAST);
    else                    phase_last = (idx_q == MEAS_LAST);
  end

  assign second_half = (phase == PH_STRESS) && (idx_q >= HALF_MARK);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_STRESS;
      idx_q <= '0;
    end else if (tick) begin
      if (phase_last) begin
        idx_q <= '0;
        phase <= (phase == PH_STRESS) ? PH_MEASURE : PH_STRESS;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/aging_slot_gen.sv
module aging_slot_gen
  import aging_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [SLOT_W-1:0] slot,
  output logic [N_PUF-1:0]  act
);

  always_ff @(posedge clk) begin
    if (rst)          slot <= '0;
    else if (advance) slot <= slot + 1'b1;
  end

  assign act = advance ? activity_mask(slot) : '0;

endmodule

// File: rtl/aging_meas_pacer.sv
module aging_meas_pacer #(
  parameter int MEAS_PERIOD = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic active,
  output logic req
);

  localparam int PW = (MEAS_PERIOD > 1) ? $clog2(MEAS_PERIOD) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(MEAS_PERIOD - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !active) cnt_q <= '0;
    else if (tick)      cnt_q <= (cnt_q == P_LAST) ? '0 : cnt_q + 1'b1;
  end

  assign req = active && tick && (cnt_q == '0);

endmodule

// File: rtl/aging_sched.sv
module aging_sched
  import aging_pkg::*;
#(
  parameter int STRESS_LEN  = 1380,
  parameter int HALF_LEN    = 690,
  parameter int MEAS_LEN    = 60,
  parameter int MEAS_PERIOD = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  output logic        stress_mode,
  output logic        measure_mode,
  output logic        hi_supply_req,
  output logic        hi_temp_req,
  output logic [63:0] challenge,
  output logic [48:0] puf_act,
  output logic        meas_req
);

  phase_e            phase;
  logic              second_half;
  logic              phase_wrap;
  logic              stress_tick;
  logic [SLOT_W-1:0] slot;

  aging_phase_timer #(
    .STRESS_LEN(STRESS_LEN),
    .HALF_LEN  (HALF_LEN),
    .MEAS_LEN  (MEAS_LEN)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .phase      (phase),
    .second_half(second_half),
    .phase_last (phase_wrap)
  );

  assign stress_mode  = (phase == PH_STRESS);
  assign measure_mode = (phase == PH_MEASURE);
  assign stress_tick  = tick && stress_mode;

  aging_slot_gen u_slots (
    .clk    (clk),
    .rst    (rst),
    .advance(stress_tick),
    .slot   (slot),
    .act    (puf_act)
  );

  aging_meas_pacer #(
    .MEAS_PERIOD(MEAS_PERIOD)
  ) u_pacer (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .active(measure_mode),
    .req   (meas_req)
  );

  assign challenge     = challenge_sel(second_half);
  assign hi_supply_req = stress_mode;
  assign hi_temp_req   = stress_mode;

endmodule

// File: rtl/aging_sched_chk.sv
module aging_sched_chk
  import aging_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              stress_mode,
  input logic              measure_mode,
  input logic              hi_supply_req,
  input logic              hi_temp_req,
  input logic [63:0]       challenge,
  input logic [48:0]       puf_act,
  input logic              meas_req,
  input logic [SLOT_W-1:0] slot,
  input logic              phase_wrap
);

  logic st_tick;
  assign st_tick = tick && stress_mode;

  a_r2_mode_excl: assert property (@(posedge clk) disable iff (rst)
    stress_mode != measure_mode);
  a_r2_wrap_flip: assert property (@(posedge clk) disable iff (rst)
    (tick && phase_wrap) |=> (stress_mode != $past(stress_mode)));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !(tick && phase_wrap) |=> $stable(stress_mode));
  a_r3_status: assert property (@(posedge clk) disable iff (rst)
    (hi_supply_req == stress_mode) && (hi_temp_req == stress_mode));
  a_r4_meas_chal: assert property (@(posedge clk) disable iff (rst)
    measure_mode |-> challenge == CHAL_LOW_ONES);
  a_r4_two_values: assert property (@(posedge clk) disable iff (rst)
    (challenge == CHAL_LOW_ONES) || (challenge == CHAL_HIGH_ONES));
  a_r5_full_group: assert property (@(posedge clk) disable iff (rst)
    st_tick |-> &puf_act[7:0]);
  a_r6_eighth_on: assert property (@(posedge clk) disable iff (rst)
    (st_tick && slot[2:0] == 3'd0) |-> &puf_act[14:8]);
  a_r6_eighth_off: assert property (@(posedge clk) disable iff (rst)
    (st_tick && slot[2:0] != 3'd0) |-> puf_act[14:8] == '0);
  a_r7_rare_on: assert property (@(posedge clk) disable iff (rst)
    (st_tick && slot == '0) |-> &puf_act[30:15]);
  a_r7_rare_off: assert property (@(posedge clk) disable iff (rst)
    (st_tick && slot != '0) |-> puf_act[30:15] == '0);
  a_r8_never_group: assert property (@(posedge clk) disable iff (rst)
    puf_act[48:31] == '0);
  a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
    !st_tick |-> puf_act == '0);
  a_r9_slot_step: assert property (@(posedge clk) disable iff (rst)
    st_tick |=> slot == $past(slot) + 1'b1);
  a_r9_slot_hold: assert property (@(posedge clk) disable iff (rst)
    !st_tick |=> $stable(slot));
  a_r10_no_req_stress: assert property (@(posedge clk) disable iff (rst)
    stress_mode |-> !meas_req);
  a_r11_idle: assert property (@(posedge clk) disable iff (rst)
    !tick |-> (!meas_req && puf_act == '0));
  a_r11_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(stress_mode) && $stable(challenge)));

endmodule

bind aging_sched aging_sched_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .tick         (tick),
  .stress_mode  (stress_mode),
  .measure_mode (measure_mode),
  .hi_supply_req(hi_supply_req),
  .hi_temp_req  (hi_temp_req),
  .challenge    (challenge),
  .puf_act      (puf_act),
  .meas_req     (meas_req),
  .slot         (slot),
  .phase_wrap   (phase_wrap)
);

// File: tb/aging_sched_tb.sv
`timescale 1ns/1ps
module aging_sched_tb;

  localparam int SL = 10;
  localparam int HL = 5;
  localparam int ML = 6;
  localparam int MP = 4;
  localparam logic [63:0] CA = 64'h0000_0000_FFFF_FFFF;
  localparam logic [63:0] CB = 64'hFFFF_FFFF_0000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        stress_mode, measure_mode, hi_supply_req, hi_temp_req, meas_req;
  logic [63:0] challenge;
  logic [48:0] puf_act;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // bench model
  bit m_stress;
  int m_idx;
  int m_slot;

  always #2.5 clk = ~clk;

  aging_sched #(.STRESS_LEN(SL), .HALF_LEN(HL), .MEAS_LEN(ML), .MEAS_PERIOD(MP)) u_dut (
    .clk(clk), .rst(rst), .tick(tick),
    .stress_mode(stress_mode), .measure_mode(measure_mode),
    .hi_supply_req(hi_supply_req), .hi_temp_req(hi_temp_req),
    .challenge(challenge), .puf_act(puf_act), .meas_req(meas_req)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [48:0] exp_act(input bit st, input int slot);
    logic [48:0] m = '0;
    if (!st) return m;
    for (int i = 0; i < 49; i++) begin
      if (i <= 7)       m[i] = 1'b1;
      else if (i <= 14) m[i] = ((slot % 8) == 0);
      else if (i <= 30) m[i] = ((slot % 64) == 0);
    end
    return m;
  endfunction

  task automatic model_reset();
    m_stress = 1'b1; m_idx = 0; m_slot = 0;
  endtask

  // compare outputs against the model for the current cycle, then advance model
  task automatic check_cycle();
    bit stk;
    stk = tick && m_stress;
    chk("R2 stress_mode", 64'(stress_mode), 64'(m_stress));
    chk("R2 measure_mode", 64'(measure_mode), 64'(!m_stress));
    chk("R3 status", {62'd0, hi_supply_req, hi_temp_req}, {62'd0, m_stress, m_stress});
    chk("R4 challenge", challenge, (m_stress && m_idx >= HL) ? CB : CA);
    if (tick) begin
      chk("R5 R6 R7 R8 R9 puf_act", 64'(puf_act), 64'(exp_act(stk, m_slot)));
      chk("R10 meas_req", 64'(meas_req), 64'(!m_stress && (m_idx % MP) == 0));
    end else begin
      chk("R11 idle puf_act", 64'(puf_act), 64'd0);
      chk("R11 idle meas_req", 64'(meas_req), 64'd0);
    end
    if (tick) begin
      if (m_stress) m_slot = (m_slot + 1) % 64;
      m_idx++;
      if (m_idx == (m_stress ? SL : ML)) begin
        m_idx = 0;
        m_stress = !m_stress;
      end
    end
  endtask

  task automatic check_reset_state();
    chk("R1 stress_mode", 64'(stress_mode), 64'd1);
    chk("R1 measure_mode", 64'(measure_mode), 64'd0);
    chk("R1 challenge", challenge, CA);
    chk("R1 puf_act", 64'(puf_act), 64'd0);
    chk("R1 meas_req", 64'(meas_req), 64'd0);
  endtask

  task automatic run(input int cycles, input int seed);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (c < 40) tick = 1'b1;                       // dense burst
      else tick = (((c + seed) * 7) % 11) < 7;       // irregular spacing
      #1;
      check_cycle();
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    model_reset();
    rst = 1'b1; tick = 1'b1;                // tick during reset must be ignored
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; tick = 1'b0;
    #1;
    check_reset_state();                     // R1
    run(1600, 0);                            // many slot wraps across windows
    // mid-campaign reset: R1
    @(negedge clk);
    rst = 1'b1; tick = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0; tick = 1'b0;
    model_reset();
    #1;
    check_reset_state();
    run(400, 3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule